// File: doc/BRIEF.md
# Character LCD Bring-Up and Text Sequencer

This block drives a character display over a four-bit nibble bus with no processor involved. After reset it runs the reset-by-instruction routine: three single-nibble function-set writes and a switch to four-bit mode, each followed by a fixed wait, with no status reads. It then sends a fixed list of configuration bytes and prints two lines of text from a built-in string source. Every full byte goes out high nibble first and low nibble second, with a short gap between the two.

After each byte the sequencer waits a settle time and polls the busy flag. A status read is two nibble reads, high nibble first. The busy flag is bit 7 of the combined status byte, which is bit 3 of the first nibble. Polling stops after a bounded number of reads. When the limit is reached, a sticky error flag is set and the sequence carries on. Once the text is written, a done output goes high. From then on, pulses on the sleep and wake inputs send display-off or display-on commands.

All waits are counted in microseconds from a tick derived from the `CLK_HZ` parameter. The nibble bus uses a one-cycle strobe. For a read strobe, the device drives `nib_rd_data` from the cycle after the strobe until the next strobe.

Top module: `lcd_bringup_seq`

## Requirements
- R1: While reset is held, `nib_stb`, `done` and `busy_err` are 0.
- R2: The first four bus writes are single nibbles with `nib_rs`=0, carrying 0x3, 0x3, 0x3, 0x2. The spacing from each to the next write is at least 5000, 100, 100 and 100 us respectively. No read strobe occurs before the first full byte.
- R3: Every full byte is sent as two write strobes: bits 7:4 first, then bits 3:0, at least 10 us apart. `nib_rs` is 0 for commands and 1 for characters, on both strobes.
- R4: The first five bytes are, in order: 0x28, 0x0C, 0x06, 0x01, 0x02.
- R5: After each byte, the first read strobe comes at least 100 us after the low-nibble write. Reads go in pairs (high, then low) with `nib_rs`=0. Pairs repeat while bit 3 of the high nibble is 1.
- R6: At most 50 read pairs are made per byte. If the 50th pair still reports busy, `busy_err` goes to 1 before the next byte and stays 1, and the sequence continues.
- R7: Line 0 is selected with command 0x80 and line 1 with command 0xA8 (DDRAM address 0x28), each just before that line's characters.
- R8: Line 0 prints "READY LCD" (9 characters). The line 1 source string is 48 characters, 'A'+(k mod 26), and is cut at 40 characters. A line ends at the string end or at the column limit, whichever comes first.
- R9: `done` rises within a few cycles after the final status read of the last character, and stays 1.
- R10: A sleep pulse sends 0x08 and a wake pulse sends 0x0C, as commands with busy polling. A request that arrives during bring-up is held and sent after `done`.
- R11: A pending request is replaced by a later request of the other kind. A sleep and a wake in the same cycle leave only the wake (0x0C).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | One-cycle request to switch the display off |
| wake_req | input | 1 | One-cycle request to switch the display on |
| nib_rd_data | input | 4 | Nibble returned by the display after a read strobe |
| nib_stb | output | 1 | One-cycle bus strobe |
| nib_rs | output | 1 | 0 = command/status, 1 = character data |
| nib_rd | output | 1 | 1 = read strobe, 0 = write strobe |
| nib_wr_data | output | 4 | Nibble being written |
| done | output | 1 | Text fully written (sticky) |
| busy_err | output | 1 | Busy poll limit reached (sticky) |

## Verification
Two functions can fall in the same cycle: the sleep and wake request inputs, and a request arriving while bring-up still owns the bus. The bench pulses sleep early in bring-up and checks that 0x08 appears only after `done`. It then raises sleep and wake in the same cycle and expects a single 0x0C. Finally, it pulses wake then sleep while a command is in flight and expects 0x08 alone. Busy lengths per byte are drawn randomly, with forced cases of 49 and 60 busy reads. The read counts are judged against min(busy+1, 50), and the timing of `busy_err` is checked across the forced timeout.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

   typedef enum logic [3:0] {
      X_IDLE, X_WR_HI, X_WAIT_GAP, X_WR_LO, X_WAIT_SET,
      X_RD_HI, X_CAP_HI, X_RD_LO, X_CAP_LO, X_FIN
   } xfer_st_e;

   typedef enum logic [2:0] {
      P_PWR, P_CFG, P_ADDR, P_TEXT, P_IDLE
   } phase_e;

   localparam logic [7:0] CMD_DISP_OFF = 8'h08;
   localparam logic [7:0] CMD_DISP_ON  = 8'h0C;
   localparam logic [7:0] CMD_DDRAM    = 8'h80;

   localparam int          LINE0_LEN  = 9;
   localparam logic [71:0] LINE0_TEXT = "READY LCD";
   localparam int          LINE1_LEN  = 48;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // bring-up nibbles: three function-set resets, then the 4-bit switch
   function automatic logic [3:0] pwr_nibble(input int step);
      return (step < 3) ? 4'h3 : 4'h2;
   endfunction

   // configuration list; the order is part of the display's contract
   function automatic logic [7:0] cfg_byte(input int step);
      case (step)
         0:       return 8'h28;   // 4-bit bus, two lines, small font
         1:       return 8'h0C;   // display on, cursor hidden
         2:       return 8'h06;   // auto-increment address
         3:       return 8'h01;   // clear
         default: return 8'h02;   // home
      endcase
   endfunction

   // string source; 0 marks the end of a line
   function automatic logic [7:0] text_char(input logic line_sel, input int col);
      logic [7:0] ch;
      ch = 8'h00;
      if (!line_sel) begin
         if (col < LINE0_LEN)
            ch = LINE0_TEXT[8*(LINE0_LEN-1-col) +: 8];
      end else begin
         if (col < LINE1_LEN)
            ch = 8'h41 + 8'(col % 26);
      end
      return ch;
   endfunction

endpackage

// File: rtl/lcd_us_tick.sv
module lcd_us_tick #(
   parameter int CLK_HZ = 50_000_000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int DIV = CLK_HZ / 1_000_000;

   if (CLK_HZ % 1_000_000 != 0 || DIV < 1) begin : g_bad_clk
      $error("lcd_us_tick: CLK_HZ must be a whole number of MHz");
   end

   if (DIV == 1) begin : g_every_cycle
      assign tick = 1'b1;
   end else begin : g_divider
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
         if (!rst_n)                   cnt <= '0;
         else if (cnt == CW'(DIV - 1)) cnt <= '0;
         else                          cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == CW'(DIV - 1));

      assert_tick_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick);
   end

endmodule

// File: rtl/lcd_us_timer.sv
module lcd_us_timer #(
   parameter int TW = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          expired
);
   logic [TW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                  cnt <= '0;
      else if (load)               cnt <= load_val;
      else if (tick && cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0) && !load;

   // R3/R5: a running wait only counts down, never restarts by itself
   assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt != '0) |=> (cnt <= $past(cnt)));

endmodule

// File: rtl/lcd_nibble_xfer.sv
module lcd_nibble_xfer
   import lcd_seq_pkg::*;
#(
   parameter int GAP_US    = 10,
   parameter int SETTLE_US = 100,
   parameter int MAX_POLLS = 50,
   parameter int TW        = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          start,
   input  logic          single,
   input  logic          rs,
   input  logic [7:0]    byte_in,
   input  logic [TW-1:0] post_us,
   input  logic [3:0]    nib_rd_data,
   output logic          nib_stb,
   output logic          nib_rs,
   output logic          nib_rd,
   output logic [3:0]    nib_wr_data,
   output logic          done,
   output logic          tmo
);
   localparam int PW = $clog2(MAX_POLLS + 1);

   if (MAX_POLLS < 1 || GAP_US < 1 || SETTLE_US < 1) begin : g_bad_cfg
      $error("lcd_nibble_xfer: counts must be at least 1");
   end
   if (GAP_US >= (1 << TW) || SETTLE_US >= (1 << TW)) begin : g_bad_tw
      $error("lcd_nibble_xfer: TW too narrow for the waits");
   end

   xfer_st_e      state;
   logic [7:0]    data_q;
   logic          rs_q;
   logic          single_q;
   logic [TW-1:0] post_q;
   logic [3:0]    hi_q;
   logic [PW-1:0] polls;
   logic          tmo_q;
   logic          t_load;
   logic [TW-1:0] t_val;
   logic          t_exp;
   logic [PW-1:0] polls_n;
   logic          unused_status;

   lcd_us_timer #(.TW(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .load(t_load), .load_val(t_val), .expired(t_exp)
   );

   always_comb begin
      t_load = 1'b0;
      t_val  = '0;
      if (state == X_WR_HI) begin
         t_load = 1'b1;
         t_val  = single_q ? post_q : TW'(GAP_US);
      end else if (state == X_WR_LO) begin
         t_load = 1'b1;
         t_val  = TW'(SETTLE_US);
      end
   end

   assign polls_n = polls + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= X_IDLE;
         data_q   <= '0;
         rs_q     <= 1'b0;
         single_q <= 1'b0;
         post_q   <= '0;
         hi_q     <= '0;
         polls    <= '0;
         tmo_q    <= 1'b0;
      end else begin
         case (state)
            X_IDLE: if (start) begin
               data_q   <= byte_in;
               rs_q     <= rs;
               single_q <= single;
               post_q   <= post_us;
               polls    <= '0;
               tmo_q    <= 1'b0;
               state    <= X_WR_HI;
            end
            X_WR_HI:    state <= X_WAIT_GAP;
            X_WAIT_GAP: if (t_exp) state <= single_q ? X_FIN : X_WR_LO;
            X_WR_LO:    state <= X_WAIT_SET;
            X_WAIT_SET: if (t_exp) state <= X_RD_HI;
            X_RD_HI:    state <= X_CAP_HI;
            X_CAP_HI: begin
               hi_q  <= nib_rd_data;
               state <= X_RD_LO;
            end
            X_RD_LO:    state <= X_CAP_LO;
            X_CAP_LO: begin
               polls <= polls_n;
               // busy flag = bit 7 of {hi, lo} = bit 3 of the first nibble
               if (!hi_q[3]) begin
                  state <= X_FIN;
               end else if (polls_n == PW'(MAX_POLLS)) begin
                  tmo_q <= 1'b1;
                  state <= X_FIN;
               end else begin
                  state <= X_RD_HI;
               end
            end
            X_FIN:      state <= X_IDLE;
            default:    state <= X_IDLE;
         endcase
      end
   end

   assign unused_status = ^{hi_q[2:0], nib_rd_data[2:0]};

   assign nib_stb     = (state == X_WR_HI) || (state == X_WR_LO) ||
                        (state == X_RD_HI) || (state == X_RD_LO);
   assign nib_rd      = (state == X_RD_HI) || (state == X_RD_LO);
   assign nib_rs      = nib_rd ? 1'b0 : rs_q;
   assign nib_wr_data = (state == X_WR_LO) ? data_q[3:0] :
                        (state == X_WR_HI) ? data_q[7:4] : 4'h0;
   assign done        = (state == X_FIN);
   assign tmo         = done && tmo_q;

   assert_polls_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
      polls <= PW'(MAX_POLLS));
   assert_low_after_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == X_WR_LO) |-> $past(t_exp));
   assert_read_is_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
      nib_rd |-> (nib_stb && !nib_rs));
   assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      nib_stb |=> !nib_stb);

endmodule

// File: rtl/lcd_bringup_seq.sv
module lcd_bringup_seq
   import lcd_seq_pkg::*;
#(
   parameter int         CLK_HZ     = 50_000_000,
   parameter int         POWER_US   = 5000,
   parameter int         STEP_US    = 100,
   parameter int         GAP_US     = 10,
   parameter int         SETTLE_US  = 100,
   parameter int         MAX_POLLS  = 50,
   parameter int         MAX_COLS   = 40,
   parameter logic [6:0] LINE1_ADDR = 7'h28
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sleep_req,
   input  logic       wake_req,
   input  logic [3:0] nib_rd_data,
   output logic       nib_stb,
   output logic       nib_rs,
   output logic       nib_rd,
   output logic [3:0] nib_wr_data,
   output logic       done,
   output logic       busy_err
);
   localparam int LONGEST = max_int(max_int(POWER_US, STEP_US), max_int(GAP_US, SETTLE_US));
   localparam int TW      = $clog2(LONGEST + 1);
   localparam int IW      = $clog2(MAX_COLS + 1) < 3 ? 3 : $clog2(MAX_COLS + 1);

   if (MAX_COLS < 1 || MAX_COLS > 80) begin : g_bad_cols
      $error("lcd_bringup_seq: MAX_COLS out of range");
   end

   phase_e        phase;
   logic [IW-1:0] idx_q;
   logic          line_q;
   logic          waiting;
   logic          sleep_pend;
   logic          wake_pend;
   logic          done_q;
   logic          err_q;

   logic          tick;
   logic          x_start;
   logic          x_single;
   logic          x_rs;
   logic [7:0]    x_byte;
   logic [TW-1:0] x_post;
   logic          x_done;
   logic          x_tmo;
   logic [7:0]    text_ch;
   logic          text_end;
   logic          req_any;

   lcd_us_tick #(.CLK_HZ(CLK_HZ)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   lcd_nibble_xfer #(
      .GAP_US(GAP_US), .SETTLE_US(SETTLE_US), .MAX_POLLS(MAX_POLLS), .TW(TW)
   ) u_xfer (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .start(x_start), .single(x_single), .rs(x_rs), .byte_in(x_byte),
      .post_us(x_post), .nib_rd_data(nib_rd_data),
      .nib_stb(nib_stb), .nib_rs(nib_rs), .nib_rd(nib_rd),
      .nib_wr_data(nib_wr_data), .done(x_done), .tmo(x_tmo)
   );

   assign text_ch  = text_char(line_q, int'(idx_q));
   assign text_end = (text_ch == 8'h00) || (idx_q == IW'(MAX_COLS));
   assign req_any  = sleep_pend || wake_pend;

   always_comb begin
      x_start  = 1'b0;
      x_single = 1'b0;
      x_rs     = 1'b0;
      x_byte   = 8'h00;
      x_post   = TW'(STEP_US);
      case (phase)
         P_PWR: begin
            x_single = 1'b1;
            x_byte   = {pwr_nibble(int'(idx_q)), 4'h0};
            x_post   = (idx_q == '0) ? TW'(POWER_US) : TW'(STEP_US);
            x_start  = !waiting;
         end
         P_CFG: begin
            x_byte  = cfg_byte(int'(idx_q));
            x_start = !waiting;
         end
         P_ADDR: begin
            x_byte  = CMD_DDRAM | {1'b0, (line_q ? LINE1_ADDR : 7'h00)};
            x_start = !waiting;
         end
         P_TEXT: begin
            x_rs    = 1'b1;
            x_byte  = text_ch;
            x_start = !waiting && !text_end;
         end
         default: begin
            x_byte  = wake_pend ? CMD_DISP_ON : CMD_DISP_OFF;
            x_start = !waiting && req_any;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= P_PWR;
         idx_q   <= '0;
         line_q  <= 1'b0;
         waiting <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         if (x_tmo) err_q <= 1'b1;
         if (x_start) waiting <= 1'b1;
         if (x_done) begin
            waiting <= 1'b0;
            case (phase)
               P_PWR: begin
                  if (idx_q == IW'(3)) begin phase <= P_CFG; idx_q <= '0; end
                  else idx_q <= idx_q + 1'b1;
               end
               P_CFG: begin
                  if (idx_q == IW'(4)) begin phase <= P_ADDR; line_q <= 1'b0; end
                  else idx_q <= idx_q + 1'b1;
               end
               P_ADDR: begin phase <= P_TEXT; idx_q <= '0; end
               P_TEXT: idx_q <= idx_q + 1'b1;
               default: ;
            endcase
         end else if (phase == P_TEXT && !waiting && text_end) begin
            if (!line_q) begin
               line_q <= 1'b1;
               phase  <= P_ADDR;
            end else begin
               phase  <= P_IDLE;
               done_q <= 1'b1;
            end
         end
      end
   end

   // request holding: issue clears, a later request of the other kind replaces,
   // a wake in the same cycle as a sleep wins
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sleep_pend <= 1'b0;
         wake_pend  <= 1'b0;
      end else begin
         if (phase == P_IDLE && !waiting && req_any) begin
            sleep_pend <= 1'b0;
            wake_pend  <= 1'b0;
         end
         if (sleep_req) begin
            sleep_pend <= 1'b1;
            wake_pend  <= 1'b0;
         end
         if (wake_req) begin
            wake_pend  <= 1'b1;
            sleep_pend <= 1'b0;
         end
      end
   end

   assign done     = done_q;
   assign busy_err = err_q;

   assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_err) |-> $past(x_tmo));
   assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);
   assert_cmd_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (nib_stb && (phase == P_PWR || phase == P_CFG || phase == P_ADDR)) |-> !nib_rs);
   assert_pend_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(sleep_pend && wake_pend));
   assert_req_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == P_IDLE) |-> done);

endmodule

// File: tb/lcd_bringup_seq_test.sv
`timescale 1ns/1ps
module lcd_bringup_seq_test;
   localparam int HZ    = 2_000_000;
   localparam int D     = HZ / 1_000_000;
   localparam int LIMIT = 150_000;
   localparam int NB    = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sleep_req = 1'b0;
   logic       wake_req = 1'b0;
   logic [3:0] nib_rd_data = 4'h0;
   logic       nib_stb, nib_rs, nib_rd, done, busy_err;
   logic [3:0] nib_wr_data;

   lcd_bringup_seq #(.CLK_HZ(HZ)) uut (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
      .nib_rd_data(nib_rd_data), .nib_stb(nib_stb), .nib_rs(nib_rs),
      .nib_rd(nib_rd), .nib_wr_data(nib_wr_data), .done(done), .busy_err(busy_err)
   );

   always #10 clk = ~clk;   // 50 MHz

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int vectors = 0, errs = 0;
   bit timed_out = 0;

   // observation log
   int   n_single = 0, nb = 0, cur = 0, busy_left = 0, early_reads = 0;
   int   s_val[4], s_rs[4], s_cyc[4];
   bit   have_hi = 0, rd_hi_next = 1, done_seen = 0;
   int   done_cyc = 0;
   logic [3:0] hi_val;
   bit   hi_rs;
   int   hi_cyc;
   logic [7:0] b_val[NB];
   bit   b_rs_hi[NB], b_rs_lo[NB], b_err_hi[NB], b_err_lo[NB], b_done_lo[NB];
   int   b_hi_cyc[NB], b_lo_cyc[NB], b_reads[NB], b_first_rd[NB], b_last_rd[NB];
   int   plan[NB];

   always @(negedge clk) if (rst_n) begin
      if (done && !done_seen) begin done_seen = 1; done_cyc = cyc; end
      if (nib_stb && !nib_rd) begin
         if (n_single < 4) begin
            s_val[n_single] = int'(nib_wr_data);
            s_rs[n_single]  = int'(nib_rs);
            s_cyc[n_single] = cyc;
            n_single++;
         end else if (!have_hi) begin
            hi_val = nib_wr_data; hi_rs = nib_rs; hi_cyc = cyc; have_hi = 1;
            if (nb < NB) b_err_hi[nb] = busy_err;
         end else if (nb < NB) begin
            b_val[nb] = {hi_val, nib_wr_data};
            b_rs_hi[nb] = hi_rs; b_rs_lo[nb] = nib_rs;
            b_hi_cyc[nb] = hi_cyc; b_lo_cyc[nb] = cyc;
            b_err_lo[nb] = busy_err; b_done_lo[nb] = done;
            b_reads[nb] = 0;
            busy_left = plan[nb]; cur = nb; nb++;
            have_hi = 0; rd_hi_next = 1;
         end
      end else if (nib_stb && nib_rd) begin
         if (nb == 0) early_reads++;
         if (rd_hi_next) begin
            if (b_reads[cur] == 0) b_first_rd[cur] = cyc;
            nib_rd_data = {busy_left > 0, 3'($urandom)};
            rd_hi_next = 0;
         end else begin
            nib_rd_data = 4'($urandom);
            b_reads[cur]++; b_last_rd[cur] = cyc;
            if (busy_left > 0) busy_left--;
            rd_hi_next = 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      vectors++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic bit in_win(input int gap, input int us);
      return (gap >= us * D - D) && (gap <= us * D + D + 6);
   endfunction

   function automatic logic [7:0] exp_byte(input int i);
      string s0 = "READY LCD";
      if (i < 5) begin
         case (i)
            0: return 8'h28;
            1: return 8'h0C;
            2: return 8'h06;
            3: return 8'h01;
            default: return 8'h02;
         endcase
      end
      if (i == 5)  return 8'h80;
      if (i < 15)  return 8'(s0[i - 6]);
      if (i == 15) return 8'hA8;
      if (i < 56)  return 8'h41 + 8'((i - 16) % 26);
      if (i == 57) return 8'h0C;
      return 8'h08;
   endfunction

   function automatic bit exp_rs(input int i);
      return (i >= 6 && i < 15) || (i >= 16 && i < 56);
   endfunction

   function automatic string tag_of(input int i);
      if (i < 5)               return "R4";
      if (i == 5 || i == 15)   return "R7";
      if (i < 56)              return "R8";
      if (i == 56)             return "R10";
      return "R11";
   endfunction

   task automatic wait_bytes(input int n);
      while (nb < n && !timed_out) begin
         @(posedge clk);
         if (cyc > LIMIT) timed_out = 1;
      end
   endtask

   task automatic pulse(input bit s, input bit w);
      @(negedge clk); sleep_req = s; wake_req = w;
      @(negedge clk); sleep_req = 0; wake_req = 0;
   endtask

   initial begin
      void'($urandom(32'h5EED));
      for (int i = 0; i < NB; i++) plan[i] = $urandom_range(0, 3);
      plan[3]  = 60;   // forced timeout on the clear command
      plan[20] = 49;   // exactly at the limit, not a timeout

      repeat (5) @(posedge clk);
      @(negedge clk);
      chk(nib_stb == 0,  "R1", "strobe in reset", nib_stb, 0);
      chk(done == 0,     "R1", "done in reset", done, 0);
      chk(busy_err == 0, "R1", "busy_err in reset", busy_err, 0);
      rst_n = 1;

      repeat (100) @(negedge clk);
      pulse(1, 0);                      // R10: request during bring-up
      while (!done_seen && !timed_out) begin
         @(posedge clk);
         if (cyc > LIMIT) timed_out = 1;
      end
      wait_bytes(57);
      repeat (400) @(posedge clk);
      pulse(1, 1);                      // R11: both in one cycle
      wait_bytes(58);
      repeat (400) @(posedge clk);
      pulse(1, 0);
      wait_bytes(59);
      pulse(0, 1);                      // R11: wake then sleep while busy
      pulse(1, 0);
      wait_bytes(60);
      repeat (600) @(posedge clk);

      // R2 power-up nibbles
      for (int k = 0; k < 4; k++) begin
         chk(s_val[k] == (k < 3 ? 3 : 2), "R2", "power-up nibble", s_val[k], k < 3 ? 3 : 2);
         chk(s_rs[k] == 0, "R2", "power-up rs", s_rs[k], 0);
      end
      chk(in_win(s_cyc[1] - s_cyc[0], 5000), "R2", "first wait", s_cyc[1] - s_cyc[0], 5000 * D);
      chk(in_win(s_cyc[2] - s_cyc[1], 100),  "R2", "second wait", s_cyc[2] - s_cyc[1], 100 * D);
      chk(in_win(s_cyc[3] - s_cyc[2], 100),  "R2", "third wait", s_cyc[3] - s_cyc[2], 100 * D);
      chk(in_win(b_hi_cyc[0] - s_cyc[3], 100), "R2", "mode-switch wait", b_hi_cyc[0] - s_cyc[3], 100 * D);
      chk(early_reads == 0, "R2", "reads before first byte", early_reads, 0);

      chk(nb == 60, "R11", "total bytes", nb, 60);
      for (int i = 0; i < 60 && i < nb; i++) begin
         int er;
         chk(b_val[i] == exp_byte(i), tag_of(i), $sformatf("byte %0d", i), b_val[i], exp_byte(i));
         chk(b_rs_hi[i] == exp_rs(i) && b_rs_lo[i] == exp_rs(i), "R3",
             $sformatf("rs of byte %0d", i), b_rs_lo[i], exp_rs(i));
         chk(in_win(b_lo_cyc[i] - b_hi_cyc[i], 10), "R3",
             $sformatf("nibble gap byte %0d", i), b_lo_cyc[i] - b_hi_cyc[i], 10 * D);
         chk(in_win(b_first_rd[i] - b_lo_cyc[i], 100), "R5",
             $sformatf("settle byte %0d", i), b_first_rd[i] - b_lo_cyc[i], 100 * D);
         er = (plan[i] + 1 < 50) ? plan[i] + 1 : 50;
         chk(b_reads[i] == er, "R5", $sformatf("read pairs byte %0d", i), b_reads[i], er);
      end

      // R6 retry limit and error timing
      chk(b_reads[3] == 50,  "R6", "pairs at timeout", b_reads[3], 50);
      chk(b_reads[20] == 50, "R6", "pairs at limit without timeout", b_reads[20], 50);
      chk(b_err_lo[3] == 0,  "R6", "busy_err before timeout", b_err_lo[3], 0);
      chk(b_err_hi[4] == 1,  "R6", "busy_err after timeout", b_err_hi[4], 1);
      chk(busy_err == 1,     "R6", "busy_err sticky", busy_err, 1);

      // R9 done timing
      chk(b_done_lo[55] == 0, "R9", "done before last char", b_done_lo[55], 0);
      chk(done_seen && (done_cyc - b_last_rd[55]) >= 1 && (done_cyc - b_last_rd[55]) <= 8,
          "R9", "done delay after last poll", done_cyc - b_last_rd[55], 4);
      chk(done == 1, "R9", "done held", done, 1);

      // R10 held request served after done
      chk(b_hi_cyc[56] > done_cyc, "R10", "held sleep after done", b_hi_cyc[56], done_cyc);

      if (timed_out) chk(0, "watchdog", "run did not complete", cyc, LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
   end

endmodule